// File: doc/BRIEF.md
# Step Attenuator Control Sequencer

This block sits between a host and an external digital step attenuator that is programmed through five parallel control lines and a latch-enable line. The host offers an attenuation code in half-decibel units. The block turns that code into a control word on the bus and produces the latch-enable timing that the attenuator needs. The attenuation in dB is the code multiplied by 0.5. The code range runs from 0, the reference (minimum) state, up to 31, which is 15.5 dB.

There are two modes. In latched mode the block puts the new word on the bus while the enable line is low and waits out a setup window. It then raises the enable line for a pulse window, lowers it, and keeps the word steady for a hold window. In direct mode the enable line stays high, so the attenuator is transparent and each accepted code shows on the bus one cycle later. The three windows are parameters given in clock cycles. To set each one, divide the minimum time in ns by the clock period and round up. At 100 MHz the minimums of 10 ns setup, 30 ns pulse and 10 ns hold become 1, 3 and 1 cycles.

Requests use a valid/ready handshake. A code is accepted on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the host must hold its request, and the block neither looks at nor stores the code. The mode input is read only while no latched sequence or hold window is running.

Top module: `step_atten_seq`

## Requirements
- R1: After reset, `latch_en` is 0, `ctl_code` is 5'b00000, `req_ready` is 1, and the block is idle in latched mode.
- R2: `ctl_code` carries the accepted code unchanged. Bit 4 weighs 8 dB, bit 3 4 dB, bit 2 2 dB, bit 1 1 dB and bit 0 0.5 dB, so code 16 sets only bit 4 and code 31 sets all five bits.
- R3: In latched mode, the cycle after a request is accepted, `ctl_code` shows the new code with `latch_en` low. It stays like this for SETUP_CYC cycles before `latch_en` rises.
- R4: In a latched sequence, `latch_en` is high for exactly PULSE_CYC consecutive cycles.
- R5: After `latch_en` falls, `ctl_code` is held and `req_ready` stays low for HOLD_CYC cycles. `req_ready` therefore returns SETUP_CYC+PULSE_CYC+HOLD_CYC cycles after acceptance.
- R6: While `req_ready` is low, a request on `req_valid`/`req_code` is ignored. `ctl_code` does not change, and the code is not applied after `req_ready` returns unless it is presented again.
- R7: `ctl_code` changes only in the cycle after an accepted handshake.
- R8: When the block is idle in latched mode and `mode_sel` is 1, `latch_en` is high one cycle later. The bus then shows the last accepted code, or the code accepted on that same edge.
- R9: In direct mode `req_ready` stays high and `latch_en` stays high. Each accepted code appears on `ctl_code` one cycle later, and back-to-back codes are taken one per cycle.
- R10: A change of `mode_sel` during a latched sequence does not alter that sequence. The change takes effect on the first edge at which the block is idle again.
- R11: In direct mode, `mode_sel`=0 drives `req_ready` low in the same cycle. `latch_en` falls one cycle later, and the bus is then held with `req_ready` low for HOLD_CYC cycles before the block returns to idle latched mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host offers a code |
| req_ready | output | 1 | Block can accept a code this cycle |
| req_code | input | 5 | Requested attenuation in 0.5 dB units |
| mode_sel | input | 1 | 1 selects direct (transparent) mode, 0 selects latched mode |
| ctl_code | output | 5 | Parallel control word to the attenuator, MSB = 8 dB |
| latch_en | output | 1 | Latch-enable line to the attenuator |

## Verification
The bench builds the block with SETUP_CYC=2, PULSE_CYC=3 and HOLD_CYC=2 instead of the defaults. Because the three windows then have different lengths, a swapped window or a count that is off by one changes the cycle at which `latch_en` or `req_ready` moves. A setup window of 2 also exercises the path where the timer counts down rather than expiring at once. A hold window of 2 makes both the hold after a latch pulse and the hold after leaving direct mode visible over more than one cycle.

// File: rtl/atten_pkg.sv
package atten_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_PULSE  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_DIRECT = 3'd4
  } seq_state_t;

  // Width needed to hold values 0..n
  function automatic int cnt_width(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/atten_window_timer.sv
// Loadable down counter; expired is high while the count is zero.
module atten_window_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/atten_seq_fsm.sv
// Sequencing of setup, pulse and hold windows plus the direct-mode state.
module atten_seq_fsm
  import atten_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             mode_sel,
  input  logic             win_expired,
  output logic             req_ready,
  output logic             capture,
  output logic             le_set,
  output logic             le_clr,
  output logic             win_load,
  output logic [CNT_W-1:0] win_val,
  output seq_state_t       state
);

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  seq_state_t state_q, state_d;
  logic       take;

  assign req_ready = (state_q == ST_IDLE) || ((state_q == ST_DIRECT) && mode_sel);
  assign take      = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    capture  = 1'b0;
    le_set   = 1'b0;
    le_clr   = 1'b0;
    win_load = 1'b0;
    win_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (mode_sel) begin
          state_d = ST_DIRECT;
          le_set  = 1'b1;
          capture = take;
        end else if (take) begin
          state_d  = ST_SETUP;
          capture  = 1'b1;
          win_load = 1'b1;
          win_val  = SETUP_LD;
        end
      end
      ST_SETUP: begin
        if (win_expired) begin
          state_d  = ST_PULSE;
          le_set   = 1'b1;
          win_load = 1'b1;
          win_val  = PULSE_LD;
        end
      end
      ST_PULSE: begin
        if (win_expired) begin
          state_d  = ST_HOLD;
          le_clr   = 1'b1;
          win_load = 1'b1;
          win_val  = HOLD_LD;
        end
      end
      ST_HOLD: begin
        if (win_expired) begin
          state_d = ST_IDLE;
        end
      end
      ST_DIRECT: begin
        if (!mode_sel) begin
          state_d  = ST_HOLD;
          le_clr   = 1'b1;
          win_load = 1'b1;
          win_val  = HOLD_LD;
        end else begin
          capture = take;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/atten_bus_reg.sv
// Registered control bus and latch-enable line.
module atten_bus_reg #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CODE_W-1:0] code_in,
  input  logic              le_set,
  input  logic              le_clr,
  output logic [CODE_W-1:0] bus_out,
  output logic              le_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_out <= '0;
      le_out  <= 1'b0;
    end else begin
      if (capture) bus_out <= code_in;
      if (le_set)      le_out <= 1'b1;
      else if (le_clr) le_out <= 1'b0;
    end
  end

endmodule

// File: rtl/step_atten_seq.sv
module step_atten_seq
  import atten_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic              mode_sel,
  output logic [CODE_W-1:0] ctl_code,
  output logic              latch_en
);

  // Each window lasts at least one cycle
  localparam int SETUP_EFF = (SETUP_CYC < 1) ? 1 : SETUP_CYC;
  localparam int PULSE_EFF = (PULSE_CYC < 1) ? 1 : PULSE_CYC;
  localparam int HOLD_EFF  = (HOLD_CYC  < 1) ? 1 : HOLD_CYC;
  localparam int MAX_WIN   = (SETUP_EFF > PULSE_EFF) ?
                             ((SETUP_EFF > HOLD_EFF) ? SETUP_EFF : HOLD_EFF) :
                             ((PULSE_EFF > HOLD_EFF) ? PULSE_EFF : HOLD_EFF);
  localparam int CNT_W     = cnt_width(MAX_WIN);

  logic             capture, le_set, le_clr, win_load, win_expired;
  logic [CNT_W-1:0] win_val;
  seq_state_t       state;

  atten_seq_fsm #(
    .SETUP_CYC (SETUP_EFF),
    .PULSE_CYC (PULSE_EFF),
    .HOLD_CYC  (HOLD_EFF),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .mode_sel    (mode_sel),
    .win_expired (win_expired),
    .req_ready   (req_ready),
    .capture     (capture),
    .le_set      (le_set),
    .le_clr      (le_clr),
    .win_load    (win_load),
    .win_val     (win_val),
    .state       (state)
  );

  atten_window_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (win_load),
    .load_val (win_val),
    .expired  (win_expired)
  );

  atten_bus_reg #(
    .CODE_W (CODE_W)
  ) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .code_in (req_code),
    .le_set  (le_set),
    .le_clr  (le_clr),
    .bus_out (ctl_code),
    .le_out  (latch_en)
  );

endmodule

// File: rtl/step_atten_seq_chk.sv
module step_atten_seq_chk
  import atten_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mode_sel,
  input logic [CODE_W-1:0] ctl_code,
  input logic              latch_en,
  input seq_state_t        st
);

  localparam int SETUP_EFF = (SETUP_CYC < 1) ? 1 : SETUP_CYC;
  localparam int PULSE_EFF = (PULSE_CYC < 1) ? 1 : PULSE_CYC;

  logic [15:0]       hi_cnt, lo_cnt;
  logic [CODE_W-1:0] prev_code;

  // hi_cnt: cycles latch_en has been high; lo_cnt: cycles bus steady with latch_en low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      prev_code <= '0;
    end else begin
      prev_code <= ctl_code;
      if (!latch_en)              hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      if (latch_en)                   lo_cnt <= '0;
      else if (ctl_code != prev_code) lo_cnt <= 16'd1;
      else if (lo_cnt != 16'hFFFF)    lo_cnt <= lo_cnt + 1'b1;
    end
  end

  a_r3_setup_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(latch_en) && st == ST_PULSE) |-> (lo_cnt >= 16'(SETUP_EFF)));

  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(latch_en) && $past(st) == ST_PULSE) |-> (hi_cnt == 16'(PULSE_EFF)));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |=> $stable(ctl_code));

  a_r5_hold_le_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> !latch_en);

  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SETUP || st == ST_PULSE || st == ST_HOLD) |-> !req_ready);

  a_r7_bus_moves_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_code) |-> $past(req_valid && req_ready));

  a_r9_direct_le_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DIRECT) |-> latch_en);

  a_r11_exit_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DIRECT && !mode_sel) |-> !req_ready);

endmodule

bind step_atten_seq step_atten_seq_chk #(
  .CODE_W    (CODE_W),
  .SETUP_CYC (SETUP_CYC),
  .PULSE_CYC (PULSE_CYC),
  .HOLD_CYC  (HOLD_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mode_sel  (mode_sel),
  .ctl_code  (ctl_code),
  .latch_en  (latch_en),
  .st        (state)
);

// File: tb/tb_step_atten_seq.sv
module tb_step_atten_seq;

  localparam int S = 2;
  localparam int P = 3;
  localparam int H = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [4:0] req_code;
  logic       mode_sel;
  logic       req_ready;
  logic [4:0] ctl_code;
  logic       latch_en;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  step_atten_seq #(
    .CODE_W (5), .SETUP_CYC (S), .PULSE_CYC (P), .HOLD_CYC (H)
  ) dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_code (req_code), .mode_sel (mode_sel), .ctl_code (ctl_code),
    .latch_en (latch_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_code = '0; mode_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 latch_en", int'(latch_en), 0);
    chk("R1 ctl_code", int'(ctl_code), 0);
    chk("R1 req_ready", int'(req_ready), 1);
  endtask

  // Full latched sequence; optionally raise mode_sel at step mode_at (-1: never)
  task automatic t_latched(input logic [4:0] code, input int mode_at);
    @(negedge clk);
    req_code = code; req_valid = 1'b1;
    chk("R5 ready before", int'(req_ready), 1);
    for (int k = 0; k <= S + P + H; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (k == mode_at) mode_sel = 1'b1;
      chk("R2 bus code", int'(ctl_code), int'(code));
      if (k < S)          chk("R3 le low in setup", int'(latch_en), 0);
      else if (k < S + P) chk("R4 le high in pulse", int'(latch_en), 1);
      else                chk("R5 le low in hold", int'(latch_en), 0);
      chk("R5 ready window", int'(req_ready), (k >= S + P + H) ? 1 : 0);
    end
  endtask

  task automatic t_ignore(input logic [4:0] a, input logic [4:0] b);
    @(negedge clk);
    req_code = a; req_valid = 1'b1;
    @(negedge clk);
    req_code = b;
    for (int k = 1; k <= S + P + H; k++) begin
      @(negedge clk);
      if (k == S + P + H - 1) req_valid = 1'b0;
      chk("R6 bus unchanged", int'(ctl_code), int'(a));
    end
    chk("R6 ready back", int'(req_ready), 1);
    @(negedge clk);
    chk("R6 no late apply", int'(ctl_code), int'(a));
    chk("R6 no pulse", int'(latch_en), 0);
  endtask

  task automatic t_mode_mid(input logic [4:0] code);
    t_latched(code, 1);
    @(negedge clk);
    chk("R10 direct after idle", int'(latch_en), 1);
    chk("R8 last code shown", int'(ctl_code), int'(code));
  endtask

  task automatic t_direct();
    @(negedge clk);
    req_valid = 1'b1; req_code = 5'd7;
    @(negedge clk);
    chk("R9 code 7", int'(ctl_code), 7);
    chk("R9 le high", int'(latch_en), 1);
    chk("R9 ready", int'(req_ready), 1);
    req_code = 5'd20;
    @(negedge clk);
    chk("R9 code 20", int'(ctl_code), 20);
    req_code = 5'd1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 code 1", int'(ctl_code), 1);
    chk("R9 le still high", int'(latch_en), 1);
  endtask

  task automatic t_exit();
    logic [4:0] held;
    @(negedge clk);
    held = ctl_code;
    mode_sel = 1'b0;
    req_valid = 1'b1; req_code = 5'd9;
    #1;
    chk("R11 ready drops", int'(req_ready), 0);
    for (int k = 0; k <= H; k++) begin
      @(negedge clk);
      if (k == H - 1) req_valid = 1'b0;
      chk("R11 le low", int'(latch_en), 0);
      chk("R11 bus held", int'(ctl_code), int'(held));
      chk("R11 ready window", int'(req_ready), (k >= H) ? 1 : 0);
    end
  endtask

  task automatic t_entry_with_code();
    @(negedge clk);
    mode_sel = 1'b1; req_valid = 1'b1; req_code = 5'd12;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 le high", int'(latch_en), 1);
    chk("R8 same-edge code", int'(ctl_code), 12);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_latched(5'd16, -1);
    chk("R2 bit4 is 8 dB", int'(ctl_code[4]), 1);
    t_latched(5'd31, -1);
    chk("R2 all bits", int'(ctl_code), 31);
    t_latched(5'd0, -1);
    t_ignore(5'd5, 5'd26);
    t_mode_mid(5'd11);
    t_direct();
    t_exit();
    t_entry_with_code();
    t_exit();
    t_latched(5'd3, -1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule